// File: doc/BRIEF.md
# Dual-Format Host Register Bus Front End

This block sits between an external parallel processor bus and a bank of sixteen internal registers. It accepts either an 8-bit bus that carries the address and then the data on the same lines, or a separate bus with four address lines and eight data lines. The format is fixed by a mode pin that is sampled while reset is held. After reset the same package pin serves as an active-low interrupt output, but only in the separate-address format and only when interrupts are enabled.

All bus strobes are brought into the system clock domain through a short synchronizer. A trailing-edge detector turns each write into exactly one write pulse. That pulse carries the captured address, the data and a one-hot register select. A companion start pulse fires when the write lands in the window of addresses that launch a serial transfer. Each read produces one read pulse and a read address. The data bus is driven with the register read data only while the chip is enabled and a read is in progress.

In the separate-address format, a shared pin selects the strobe convention. One convention uses active-low read and write strobes. The other uses an active-high data strobe together with a direction line. In the shared-bus format, that pin is the address latch strobe instead, and the strobe convention comes from a parameter.

Top module: `host_bus_if`

## Requirements
- R1: The bus format is taken from `modeIn` on every clock edge while `rstN` is low and is then held until the next reset. A low level gives `muxMode`=1 (shared address/data bus) and a high level gives `muxMode`=0. While `rstN` is low, `wrStrobe`, `rdStrobe` and `xferStart` stay 0.
- R2: With `muxMode`=1, the register address is `busIn[3:0]` as last seen while `asMi` was high. It is held after `asMi` falls and is used by every following access until the next address phase.
- R3: With `muxMode`=0 and `asMi`=1, `wrRw` is an active-low write strobe and `rdDs` is an active-low read strobe. The address comes from `addrIn`.
- R4: With `muxMode`=0 and `asMi`=0, `rdDs` is an active-high data strobe and `wrRw` gives the direction: 1 means read and 0 means write.
- R5: Each write access gives exactly one single-cycle `wrStrobe`, a few clocks after the write strobe ends. At that point `wrAddr`/`wrData` hold the access's address and data, and `wrSel` has exactly bit `wrAddr` set.
- R6: `xferStart` pulses together with `wrStrobe` only when `wrAddr` is between 1 and 9 inclusive. Writes to 0 and to 10..15 do not start a transfer.
- R7: While `ceN` is high, no strobe activity produces `wrStrobe` or `rdStrobe`, and `busOe` stays 0.
- R8: `busOe` is 1 exactly while `ceN` is low and a read is active in the current convention. While `busOe` is 1, `busOut` equals `regRdData`; otherwise `busOut` is 0.
- R9: Each read access gives exactly one single-cycle `rdStrobe`. While that read is active, `rdAddr` equals the read address.
- R10: `intOe` is 1 only when `muxMode`=0 and `intEn`=1. When `intOe` is 1, `intOutN` is the inverse of `intReq`; otherwise `intOutN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, also the mode sampling window |
| modeIn | input | 1 | Mode pin level (low = shared bus) |
| intEn | input | 1 | Interrupt output enable |
| intReq | input | 1 | Interrupt request from the register bank |
| intOutN | output | 1 | Active-low interrupt level for the mode pin |
| intOe | output | 1 | Output enable for the mode pin driver |
| ceN | input | 1 | Active-low chip enable |
| asMi | input | 1 | Address strobe (shared bus) or convention select |
| rdDs | input | 1 | Read strobe or data strobe |
| wrRw | input | 1 | Write strobe or read/write direction |
| addrIn | input | 4 | Address lines (separate-address format) |
| busIn | input | 8 | Data, or address then data, from the bus |
| busOut | output | 8 | Read data toward the bus |
| busOe | output | 1 | Bus driver enable |
| muxMode | output | 1 | Latched format: 1 = shared address/data bus |
| wrStrobe | output | 1 | One-cycle register write pulse |
| xferStart | output | 1 | One-cycle pulse for a write that starts a transfer |
| wrAddr | output | 4 | Address of the write |
| wrData | output | 8 | Data of the write |
| wrSel | output | 16 | One-hot register write select |
| rdStrobe | output | 1 | One-cycle read pulse |
| rdAddr | output | 4 | Current read address |
| regRdData | input | 8 | Read data from the register bank |

## Verification
Two functions can fall in the same clock cycle: the trailing-edge write pulse of one access and the leading-edge read pulse of the next. The bench provokes this on the separate-strobe convention by releasing the write strobe and asserting the read strobe in the same instant with the address held. The check requires both pulses in one and the same clock cycle. The write must still carry its own address, data and start pulse, and the read must still drive the bus with the right value.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int SYNC_DEPTH = 2;

  typedef struct packed {
    logic capture;
    logic wrPulse;
    logic rdPulse;
    logic aleHold;
  } hbi_strb_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[0] <= RST_VAL;
        else       stg[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[g] <= RST_VAL;
        else       stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter bit MUX_DS_STYLE = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeIn,
  input  logic      ceN,
  input  logic      asMi,
  input  logic      rdDs,
  input  logic      wrRw,
  output logic      muxMode,
  output logic      busOe,
  output hbi_strb_t strb
);
  logic modeReg;
  logic [3:0] rawCtl, syncCtl;
  logic asS, ceS, rdS, wrS;
  logic dsStyle, rawDsStyle;
  logic wrAct, rdAct, wrPrev, rdPrev;

  // mode pin loads during reset, then freezes
  always_ff @(posedge clk)
    if (!rstN) modeReg <= modeIn;

  assign muxMode = ~modeReg;

  assign rawCtl = {asMi, ceN, rdDs, wrRw};

  hbi_sync #(.W(4), .DEPTH(SYNC_DEPTH), .RST_VAL(4'b0100)) u_ctlSync (
    .clk(clk), .rstN(rstN), .din(rawCtl), .dout(syncCtl)
  );

  assign {asS, ceS, rdS, wrS} = syncCtl;

  assign dsStyle = muxMode ? MUX_DS_STYLE : ~asS;
  assign wrAct   = ~ceS & (dsStyle ? (rdS & ~wrS) : ~wrS);
  assign rdAct   = ~ceS & (dsStyle ? (rdS &  wrS) : ~rdS);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
    end

  assign strb.capture = wrAct | rdAct;
  assign strb.wrPulse = wrPrev & ~wrAct;
  assign strb.rdPulse = rdAct & ~rdPrev;
  assign strb.aleHold = muxMode & asS;

  // bus drive follows the raw pins so read data appears without sync delay
  assign rawDsStyle = muxMode ? MUX_DS_STYLE : ~asMi;
  assign busOe = ~ceN & (rawDsStyle ? (rdDs & wrRw) : ~rdDs);

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPulse |=> !strb.wrPulse);

  p_rd_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdPulse |=> !strb.rdPulse);

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(muxMode));

  p_no_drive_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !busOe);
endmodule

// File: rtl/hbi_dp.sv
module hbi_dp
  import hbi_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int START_LO = 1,
  parameter int START_HI = 9,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            muxMode,
  input  hbi_strb_t       strb,
  input  logic [AW-1:0]   addrIn,
  input  logic [DW-1:0]   busIn,
  output logic            wrStrobe,
  output logic            xferStart,
  output logic [AW-1:0]   wrAddr,
  output logic [DW-1:0]   wrData,
  output logic [NREG-1:0] wrSel,
  output logic            rdStrobe,
  output logic [AW-1:0]   rdAddr
);
  logic [AW+DW-1:0] rawBus, syncBus;
  logic [AW-1:0] addrS, addrLatch, curAddr, capAddr;
  logic [DW-1:0] busS, capData;
  logic inWindow;

  assign rawBus = {addrIn, busIn};

  hbi_sync #(.W(AW+DW), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_busSync (
    .clk(clk), .rstN(rstN), .din(rawBus), .dout(syncBus)
  );

  assign {addrS, busS} = syncBus;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             addrLatch <= '0;
    else if (strb.aleHold) addrLatch <= busS[AW-1:0];

  assign curAddr = muxMode ? addrLatch : addrS;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (strb.capture) begin
      capAddr <= curAddr;
      capData <= busS;
    end

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wrSel[i] = strb.wrPulse && (capAddr == AW'(i));
  end

  assign inWindow  = (32'(capAddr) >= START_LO) && (32'(capAddr) <= START_HI);
  assign wrStrobe  = strb.wrPulse;
  assign xferStart = strb.wrPulse & inWindow;
  assign wrAddr    = capAddr;
  assign wrData    = capData;
  assign rdStrobe  = strb.rdPulse;
  assign rdAddr    = curAddr;

  p_start_needs_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> wrStrobe);

  p_sel_follows_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $countones(wrSel) == 1);
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import hbi_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int START_LO = 1,
  parameter int START_HI = 9,
  parameter bit MUX_DS_STYLE = 1'b0,
  localparam int NREG = 1 << AW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeIn,
  input  logic            intEn,
  input  logic            intReq,
  output logic            intOutN,
  output logic            intOe,
  input  logic            ceN,
  input  logic            asMi,
  input  logic            rdDs,
  input  logic            wrRw,
  input  logic [AW-1:0]   addrIn,
  input  logic [DW-1:0]   busIn,
  output logic [DW-1:0]   busOut,
  output logic            busOe,
  output logic            muxMode,
  output logic            wrStrobe,
  output logic            xferStart,
  output logic [AW-1:0]   wrAddr,
  output logic [DW-1:0]   wrData,
  output logic [NREG-1:0] wrSel,
  output logic            rdStrobe,
  output logic [AW-1:0]   rdAddr,
  input  logic [DW-1:0]   regRdData
);
  hbi_strb_t strb;

  hbi_ctrl #(.MUX_DS_STYLE(MUX_DS_STYLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .ceN(ceN), .asMi(asMi),
    .rdDs(rdDs), .wrRw(wrRw), .muxMode(muxMode), .busOe(busOe), .strb(strb)
  );

  hbi_dp #(.AW(AW), .DW(DW), .START_LO(START_LO), .START_HI(START_HI)) u_dp (
    .clk(clk), .rstN(rstN), .muxMode(muxMode), .strb(strb),
    .addrIn(addrIn), .busIn(busIn), .wrStrobe(wrStrobe), .xferStart(xferStart),
    .wrAddr(wrAddr), .wrData(wrData), .wrSel(wrSel),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr)
  );

  assign busOut  = busOe ? regRdData : '0;
  assign intOe   = ~muxMode & intEn;
  assign intOutN = intOe ? ~intReq : 1'b1;

  p_int_quiet_mux_r10: assert property (@(posedge clk) disable iff (!rstN)
    muxMode |-> (!intOe && intOutN));
endmodule

// File: tb/host_bus_if_tb.sv
module host_bus_if_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, modeIn = 1'b1, intEn = 1'b0, intReq = 1'b0;
  logic ceN = 1'b1, asMi = 1'b1, rdDs = 1'b1, wrRw = 1'b1;
  logic [3:0] addrIn = '0;
  logic [7:0] busIn = '0;
  logic intOutN, intOe, busOe, muxMode, wrStrobe, xferStart, rdStrobe;
  logic [7:0] busOut, wrData, regRdData;
  logic [3:0] wrAddr, rdAddr;
  logic [15:0] wrSel;

  int errors = 0, checks = 0;
  int cyc = 0, wrCnt = 0, rdCnt = 0, startCnt = 0, wrCyc = 0, rdCyc = 0, rstPulses = 0;
  logic [3:0] lastWrAddr, lastRdAddr;
  logic [7:0] lastWrData;
  logic [15:0] lastSel;
  bit done = 0;

  always #5 clk = ~clk;

  assign regRdData = {4'hA, rdAddr};

  host_bus_if u_dut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .intEn(intEn), .intReq(intReq),
    .intOutN(intOutN), .intOe(intOe), .ceN(ceN), .asMi(asMi), .rdDs(rdDs),
    .wrRw(wrRw), .addrIn(addrIn), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .muxMode(muxMode), .wrStrobe(wrStrobe), .xferStart(xferStart),
    .wrAddr(wrAddr), .wrData(wrData), .wrSel(wrSel), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .regRdData(regRdData)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rstN && (wrStrobe || rdStrobe || xferStart)) rstPulses++;
    if (rstN && wrStrobe) begin
      wrCnt++; wrCyc = cyc; lastWrAddr = wrAddr; lastWrData = wrData; lastSel = wrSel;
      if (xferStart) startCnt++;
    end
    if (rstN && rdStrobe) begin
      rdCnt++; rdCyc = cyc; lastRdAddr = rdAddr;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic doReset(input logic m);
    rstN = 1'b0; modeIn = m; ceN = 1'b1;
    waitc(5);
    check(rstPulses == 0, "R1 no pulses in reset", rstPulses, 0);
    rstN = 1'b1;
    waitc(1);
    modeIn = ~m;
    waitc(3);
    check(muxMode == ~m, "R1 mode latched", muxMode, ~m);
  endtask

  // separate strobes, non-multiplexed
  task automatic sepWrite(input logic [3:0] a, input logic [7:0] d);
    asMi = 1'b1; rdDs = 1'b1; addrIn = a; busIn = d; ceN = 1'b0;
    waitc(1); wrRw = 1'b0; waitc(4); wrRw = 1'b1; waitc(1); ceN = 1'b1; waitc(5);
  endtask

  task automatic sepRead(input logic [3:0] a, input string req);
    int r0 = rdCnt;
    asMi = 1'b1; wrRw = 1'b1; addrIn = a; ceN = 1'b0;
    waitc(1); rdDs = 1'b0; waitc(4);
    check(busOe == 1'b1, {req, " R8 bus driven"}, busOe, 1);
    check(busOut == {4'hA, a}, {req, " R8 read data"}, busOut, {4'hA, a});
    rdDs = 1'b1; waitc(1); ceN = 1'b1; waitc(1);
    check(busOe == 1'b0, {req, " R8 bus released"}, busOe, 0);
    waitc(4);
    check(rdCnt - r0 == 1 && lastRdAddr == a, {req, " R9 one read pulse"}, lastRdAddr, a);
  endtask

  task automatic testSepWrites;
    int w0 = wrCnt, s0 = startCnt;
    sepWrite(4'h5, 8'h3C);
    check(wrCnt - w0 == 1, "R3 R5 one write pulse", wrCnt - w0, 1);
    check(lastWrAddr == 4'h5 && lastWrData == 8'h3C, "R5 write payload",
          {lastWrAddr, lastWrData}, 12'h53C);
    check(lastSel == 16'h0020, "R5 one-hot select", lastSel, 16'h0020);
    check(startCnt - s0 == 1, "R6 start at addr 5", startCnt - s0, 1);
    s0 = startCnt;
    sepWrite(4'h0, 8'h11);
    check(startCnt - s0 == 0 && lastWrAddr == 0, "R6 no start at addr 0", startCnt - s0, 0);
    sepWrite(4'hA, 8'h22);
    check(startCnt - s0 == 0 && lastWrAddr == 4'hA, "R6 no start at addr 10", startCnt - s0, 0);
    sepWrite(4'h9, 8'h33);
    check(startCnt - s0 == 1, "R6 start at addr 9", startCnt - s0, 1);
    sepWrite(4'h1, 8'h44);
    check(startCnt - s0 == 2, "R6 start at addr 1", startCnt - s0, 2);
  endtask

  task automatic testCeHigh;
    int w0 = wrCnt, r0 = rdCnt;
    asMi = 1'b1; ceN = 1'b1; addrIn = 4'h3;
    wrRw = 1'b0; waitc(4); wrRw = 1'b1; waitc(2);
    rdDs = 1'b0; waitc(2);
    check(busOe == 1'b0, "R7 no drive when disabled", busOe, 0);
    rdDs = 1'b1; waitc(5);
    check(wrCnt == w0 && rdCnt == r0, "R7 no strobes when disabled", wrCnt - w0 + rdCnt - r0, 0);
  endtask

  task automatic testDsStyle;
    int w0 = wrCnt, r0 = rdCnt;
    asMi = 1'b0; rdDs = 1'b0; wrRw = 1'b1; waitc(3);
    addrIn = 4'h7; busIn = 8'h5A; wrRw = 1'b0; ceN = 1'b0;
    waitc(1); rdDs = 1'b1; waitc(4); rdDs = 1'b0; waitc(1); wrRw = 1'b1; ceN = 1'b1; waitc(5);
    check(wrCnt - w0 == 1 && lastWrAddr == 4'h7 && lastWrData == 8'h5A,
          "R4 data-strobe write", {lastWrAddr, lastWrData}, 12'h75A);
    addrIn = 4'h2; ceN = 1'b0; wrRw = 1'b1; waitc(1); rdDs = 1'b1; waitc(4);
    check(busOe == 1'b1 && busOut == 8'hA2, "R4 R8 data-strobe read", busOut, 8'hA2);
    rdDs = 1'b0; waitc(1); ceN = 1'b1; waitc(5);
    check(rdCnt - r0 == 1 && lastRdAddr == 4'h2, "R4 R9 one read pulse", rdCnt - r0, 1);
    asMi = 1'b1; rdDs = 1'b1; waitc(3);
  endtask

  task automatic testInterrupt(input logic expOe);
    intEn = 1'b1; intReq = 1'b1; #1;
    check(intOe == expOe && intOutN == ~expOe, "R10 interrupt enabled", {intOe, intOutN}, {expOe, ~expOe});
    intReq = 1'b0; #1;
    check(intOutN == 1'b1, "R10 interrupt idle high", intOutN, 1);
    intEn = 1'b0; intReq = 1'b1; #1;
    check(intOe == 1'b0 && intOutN == 1'b1, "R10 interrupt disabled", {intOe, intOutN}, 2'b01);
    intReq = 1'b0;
  endtask

  task automatic testOverlap;
    int w0 = wrCnt, r0 = rdCnt, s0 = startCnt;
    asMi = 1'b1; rdDs = 1'b1; addrIn = 4'h6; busIn = 8'h99; ceN = 1'b0;
    waitc(1); wrRw = 1'b0; waitc(4);
    wrRw = 1'b1; rdDs = 1'b0; waitc(5);
    check(busOe == 1'b1 && busOut == 8'hA6, "R8 overlap read data", busOut, 8'hA6);
    rdDs = 1'b1; ceN = 1'b1; waitc(5);
    check(wrCnt - w0 == 1 && rdCnt - r0 == 1, "R5 R9 overlap both pulses", wrCnt - w0 + rdCnt - r0, 2);
    check(wrCyc == rdCyc, "R5 R9 overlap same cycle", wrCyc, rdCyc);
    check(lastWrAddr == 4'h6 && lastWrData == 8'h99 && startCnt - s0 == 1,
          "R5 R6 overlap payload", {lastWrAddr, lastWrData}, 12'h699);
  endtask

  task automatic muxAddr(input logic [3:0] a);
    busIn = {4'h5, a}; asMi = 1'b1; waitc(4); asMi = 1'b0; busIn = 8'hF0; waitc(3);
  endtask

  task automatic testMux;
    int w0 = wrCnt, r0 = rdCnt;
    asMi = 1'b0; wrRw = 1'b1; rdDs = 1'b1; addrIn = 4'hF;
    muxAddr(4'h3);
    busIn = 8'hC3; ceN = 1'b0; waitc(1); wrRw = 1'b0; waitc(4); wrRw = 1'b1; waitc(1); ceN = 1'b1; waitc(5);
    check(wrCnt - w0 == 1 && lastWrAddr == 4'h3 && lastWrData == 8'hC3,
          "R2 muxed write", {lastWrAddr, lastWrData}, 12'h3C3);
    muxAddr(4'hE);
    busIn = 8'h00; ceN = 1'b0; waitc(1); rdDs = 1'b0; waitc(4);
    check(busOe == 1'b1 && busOut == 8'hAE, "R2 R8 muxed read", busOut, 8'hAE);
    rdDs = 1'b1; waitc(1); ceN = 1'b1; waitc(5);
    check(rdCnt - r0 == 1 && lastRdAddr == 4'hE, "R2 R9 muxed read pulse", lastRdAddr, 4'hE);
    w0 = wrCnt;
    busIn = 8'h77; ceN = 1'b0; waitc(1); wrRw = 1'b0; waitc(4); wrRw = 1'b1; waitc(1); ceN = 1'b1; waitc(5);
    check(wrCnt - w0 == 1 && lastWrAddr == 4'hE, "R2 address held", lastWrAddr, 4'hE);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    check(wrStrobe == 0 && rdStrobe == 0 && busOe == 0, "R1 idle after reset",
          {wrStrobe, rdStrobe, busOe}, 0);
    testSepWrites();
    sepRead(4'h7, "R3");
    testCeHigh();
    testDsStyle();
    testInterrupt(1'b1);
    testOverlap();
    doReset(1'b0);
    testInterrupt(1'b0);
    testMux();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule